// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the timing skeleton of an interlaced video raster. It advances one pixel position on every cycle in which the pixel-clock enable is high. From that position it derives the horizontal position, the line number within the current field, a field identifier, active-low horizontal and vertical sync, a combined blanking flag and a mid-line marker. A frame is made of two fields. Each field lasts an odd number of half-lines, so a field boundary always lands in the middle of a scan line. Because of this, the vertical sync of the second field starts half a line later, relative to horizontal sync, than the vertical sync of the first field. That offset is what makes the scan lines of the two fields interleave.

Two cooperating state machines do the work. The horizontal machine walks a line through four segments:

- `HS_VIS`, the visible pixels
- `HS_FRONT`, the front porch
- `HS_PULSE`, the sync pulse
- `HS_BACK`, the back porch

It emits a tick at the line start and at the mid-line point. The vertical machine counts those half-line ticks through five segments: `VS_FRONT`, `VS_PULSE`, `VS_BACK`, `VS_VIS` and `VS_TAIL`. The transitions of the horizontal machine are:

- VIS→FRONT after pixel `H_ACTIVE-1`
- FRONT→PULSE after the last front-porch pixel
- PULSE→BACK after the last sync pixel
- BACK→VIS on the line wrap

The transitions of the vertical machine are:

- FRONT→PULSE on reaching half-line `2*V_FPORCH`
- PULSE→BACK on reaching half-line `2*(V_FPORCH+V_SYNC)`
- BACK→VIS on reaching the first visible half-line. This is half-line `2*VB` in field 0 and half-line `2*VB-1` in field 1, where VB is `V_FPORCH+V_SYNC+V_BPORCH`.
- VIS→TAIL on reaching the end of the visible lines.
- any state→FRONT on the field wrap, which also toggles the field.

With the default parameters, a field is 262 full lines plus one half-line, 240 of them visible. A frame is 525 lines.

Top module: `ilace_timing`

## Requirements
- R1: A synchronous reset (`rst` high) sets `h_pos`=0, `line_pos`=0 and `field_id`=0, with `hsync_n`=1, `vsync_n`=1, `mid_line`=0 and `blank`=1 on the cycle after the reset edge.
- R2: While `pix_en` is low, no output changes.
- R3: On each enabled cycle, `h_pos` advances by one. It wraps from H_TOTAL-1 (the sum of the four horizontal parameters) to 0. `line_pos` increments on that wrap, except at the end of a field.
- R4: `hsync_n` is 0 exactly when `h_pos` lies in [H_ACTIVE+H_FPORCH, H_ACTIVE+H_FPORCH+H_SYNC), and is 1 otherwise.
- R5: `mid_line` is 1 exactly when `h_pos` equals H_TOTAL/2.
- R6: Let VL = V_FPORCH+V_SYNC+V_BPORCH+V_ACTIVE.
  - Field 0 (`field_id`=0) starts at `line_pos`=0, `h_pos`=0. It ends after `h_pos`=H_TOTAL/2-1 of `line_pos`=VL.
  - Field 1 then starts at `line_pos`=0, `h_pos`=H_TOTAL/2. It ends after `h_pos`=H_TOTAL-1 of `line_pos`=VL.
  - `field_id` toggles at each field end, and `line_pos` restarts at 0.
- R7: In field 0, `vsync_n` is 0 for `line_pos` in [V_FPORCH, V_FPORCH+V_SYNC), with both edges at `h_pos`=0. In field 1, `vsync_n` is 0 from (`line_pos`=V_FPORCH, `h_pos`=H_TOTAL/2) up to, but not including, (`line_pos`=V_FPORCH+V_SYNC, `h_pos`=H_TOTAL/2), so both of its edges fall on the mid-line marker.
- R8: `blank` is 0 only when both of these hold, in either field:
  - `h_pos` < H_ACTIVE
  - `line_pos` lies in [VB, VB+V_ACTIVE), where VB = V_FPORCH+V_SYNC+V_BPORCH

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable; one pixel step per enabled cycle |
| h_pos | output | HW | Pixel position within the line |
| line_pos | output | LW | Line number within the current field |
| field_id | output | 1 | Field identifier (0 or 1) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| mid_line | output | 1 | High at the half-line position |

## Verification
The bench targets the half-line seam between the fields.

- A design that ends field 0 on a full line, or that starts field 1 at pixel 0, shows a wrong `line_pos`/`h_pos` pair at the field swap, and a frame that contains an even number of lines.
- Vertical sync in field 1 is checked for both of its edges on the mid-line point. A design that aligns field-1 vertical sync to the line start loses the interleave, and its falling edge appears at `h_pos`=0.
- The first visible line of field 1 is reached one half-line earlier in half-line count than in field 0. An error there shows up as blanking that is shifted by half a line.
- Stalls of `pix_en` check that nothing moves, including the field bit and the vertical state.

// File: rtl/ilace_pkg.sv
package ilace_pkg;

    // horizontal segments of one scan line
    typedef enum logic [1:0] {
        HS_VIS,
        HS_FRONT,
        HS_PULSE,
        HS_BACK
    } hseg_t;

    // vertical segments of one field, walked in half-line steps
    typedef enum logic [2:0] {
        VS_FRONT,
        VS_PULSE,
        VS_BACK,
        VS_VIS,
        VS_TAIL
    } vseg_t;

endpackage

// File: rtl/ilace_hscan.sv
module ilace_hscan
    import ilace_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FPORCH = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BPORCH = 48,
    localparam int H_TOTAL = H_ACTIVE + H_FPORCH + H_SYNC + H_BPORCH,
    localparam int HW      = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    output logic [HW-1:0] h_pos,
    output hseg_t         h_seg,
    output logic          half_tick
);

    localparam logic [HW-1:0] LAST_PX  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] VIS_END  = HW'(H_ACTIVE - 1);
    localparam logic [HW-1:0] FP_END   = HW'(H_ACTIVE + H_FPORCH - 1);
    localparam logic [HW-1:0] PUL_END  = HW'(H_ACTIVE + H_FPORCH + H_SYNC - 1);
    localparam logic [HW-1:0] HALF_M1  = HW'(H_TOTAL / 2 - 1);

    hseg_t         seg_nx;
    logic [HW-1:0] pos_nx;

    // next-state logic
    always_comb begin
        seg_nx = h_seg;
        pos_nx = (h_pos == LAST_PX) ? '0 : h_pos + 1'b1;
        unique case (h_seg)
            HS_VIS:   if (h_pos == VIS_END) seg_nx = HS_FRONT;
            HS_FRONT: if (h_pos == FP_END)  seg_nx = HS_PULSE;
            HS_PULSE: if (h_pos == PUL_END) seg_nx = HS_BACK;
            HS_BACK:  if (h_pos == LAST_PX) seg_nx = HS_VIS;
            default:  seg_nx = HS_VIS;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            h_seg <= HS_VIS;
            h_pos <= '0;
        end else if (pix_en) begin
            h_seg <= seg_nx;
            h_pos <= pos_nx;
        end
    end

    // half-line step: the next position is either line start or mid-line
    always_comb begin
        half_tick = pix_en && ((h_pos == HALF_M1) || (h_pos == LAST_PX));
    end

endmodule

// File: rtl/ilace_vscan.sv
module ilace_vscan
    import ilace_pkg::*;
#(
    parameter int V_ACTIVE = 240,
    parameter int V_FPORCH = 3,
    parameter int V_SYNC   = 3,
    parameter int V_BPORCH = 16,
    localparam int V_LINES = V_FPORCH + V_SYNC + V_BPORCH + V_ACTIVE,
    localparam int F_HALVES = 2 * V_LINES + 1,
    localparam int FHW     = $clog2(F_HALVES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           half_tick,
    output logic [FHW-1:0] half_idx,
    output logic           field_id,
    output vseg_t          v_seg
);

    localparam int VB = V_FPORCH + V_SYNC + V_BPORCH;
    localparam logic [FHW-1:0] LAST_HALF = FHW'(F_HALVES - 1);
    localparam logic [FHW-1:0] PUL_BEG   = FHW'(2 * V_FPORCH);
    localparam logic [FHW-1:0] PUL_END   = FHW'(2 * (V_FPORCH + V_SYNC));
    localparam logic [FHW-1:0] VIS_BEG0  = FHW'(2 * VB);
    localparam logic [FHW-1:0] VIS_BEG1  = FHW'(2 * VB - 1);
    localparam logic [FHW-1:0] VIS_END0  = FHW'(2 * (VB + V_ACTIVE));
    localparam logic [FHW-1:0] VIS_END1  = FHW'(2 * (VB + V_ACTIVE) - 1);

    vseg_t          seg_nx;
    logic [FHW-1:0] idx_nx;
    logic           fld_nx;
    logic [FHW-1:0] vis_beg;
    logic [FHW-1:0] vis_end;

    // field 1 is offset by a half-line, so its visible window starts one step earlier
    always_comb begin
        vis_beg = field_id ? VIS_BEG1 : VIS_BEG0;
        vis_end = field_id ? VIS_END1 : VIS_END0;
    end

    // next-state logic, evaluated per half-line step
    always_comb begin
        seg_nx = v_seg;
        fld_nx = field_id;
        idx_nx = half_idx + 1'b1;
        if (half_idx == LAST_HALF) begin
            idx_nx = '0;
            fld_nx = ~field_id;
            seg_nx = VS_FRONT;
        end else begin
            unique case (v_seg)
                VS_FRONT: if (idx_nx == PUL_BEG) seg_nx = VS_PULSE;
                VS_PULSE: if (idx_nx == PUL_END) seg_nx = VS_BACK;
                VS_BACK:  if (idx_nx == vis_beg) seg_nx = VS_VIS;
                VS_VIS:   if (idx_nx == vis_end) seg_nx = VS_TAIL;
                VS_TAIL:  seg_nx = VS_TAIL;
                default:  seg_nx = VS_FRONT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            v_seg    <= VS_FRONT;
            half_idx <= '0;
            field_id <= 1'b0;
        end else if (half_tick) begin
            v_seg    <= seg_nx;
            half_idx <= idx_nx;
            field_id <= fld_nx;
        end
    end

endmodule

// File: rtl/ilace_timing.sv
module ilace_timing
    import ilace_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FPORCH = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BPORCH = 48,
    parameter int V_ACTIVE = 240,
    parameter int V_FPORCH = 3,
    parameter int V_SYNC   = 3,
    parameter int V_BPORCH = 16,
    localparam int H_TOTAL = H_ACTIVE + H_FPORCH + H_SYNC + H_BPORCH,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int V_LINES = V_FPORCH + V_SYNC + V_BPORCH + V_ACTIVE,
    localparam int LW      = $clog2(V_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    output logic [HW-1:0] h_pos,
    output logic [LW-1:0] line_pos,
    output logic          field_id,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank,
    output logic          mid_line
);

    localparam int FHW = $clog2(2 * V_LINES + 1);
    localparam logic [HW-1:0] HALF_PX = HW'(H_TOTAL / 2);

    hseg_t          h_seg;
    vseg_t          v_seg;
    logic           half_tick;
    logic [FHW-1:0] half_idx;
    logic [FHW:0]   idx_up;

    ilace_hscan #(
        .H_ACTIVE(H_ACTIVE),
        .H_FPORCH(H_FPORCH),
        .H_SYNC  (H_SYNC),
        .H_BPORCH(H_BPORCH)
    ) u_hscan (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .h_pos    (h_pos),
        .h_seg    (h_seg),
        .half_tick(half_tick)
    );

    ilace_vscan #(
        .V_ACTIVE(V_ACTIVE),
        .V_FPORCH(V_FPORCH),
        .V_SYNC  (V_SYNC),
        .V_BPORCH(V_BPORCH)
    ) u_vscan (
        .clk      (clk),
        .rst      (rst),
        .half_tick(half_tick),
        .half_idx (half_idx),
        .field_id (field_id),
        .v_seg    (v_seg)
    );

    // output process: decode both state machines
    always_comb begin
        // field 1 opens with a half line numbered 0, so round its half count up
        idx_up   = {1'b0, half_idx} + (FHW + 1)'(field_id);
        line_pos = LW'(idx_up >> 1);
        hsync_n  = (h_seg != HS_PULSE);
        vsync_n  = (v_seg != VS_PULSE);
        blank    = (h_seg != HS_VIS) || (v_seg != VS_VIS);
        mid_line = (h_pos == HALF_PX);
    end

endmodule

// File: rtl/ilace_timing_chk.sv
module ilace_timing_chk #(
    parameter int H_ACTIVE = 640,
    parameter int H_FPORCH = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BPORCH = 48,
    parameter int V_ACTIVE = 240,
    parameter int V_FPORCH = 3,
    parameter int V_SYNC   = 3,
    parameter int V_BPORCH = 16,
    localparam int H_TOTAL = H_ACTIVE + H_FPORCH + H_SYNC + H_BPORCH,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int V_LINES = V_FPORCH + V_SYNC + V_BPORCH + V_ACTIVE,
    localparam int LW      = $clog2(V_LINES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          pix_en,
    input logic [HW-1:0] h_pos,
    input logic [LW-1:0] line_pos,
    input logic          field_id,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          blank,
    input logic          mid_line
);

    localparam logic [HW-1:0] LAST_PX = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] HALF_PX = HW'(H_TOTAL / 2);
    localparam logic [HW-1:0] HALF_M1 = HW'(H_TOTAL / 2 - 1);
    localparam logic [LW-1:0] VIS_LN  = LW'(V_FPORCH + V_SYNC + V_BPORCH);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (h_pos == '0 && line_pos == '0 && !field_id && hsync_n && vsync_n && blank));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(h_pos) && $stable(line_pos) && $stable(field_id)
                     && $stable(vsync_n) && $stable(blank)));

    // R3
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && h_pos == LAST_PX) |=> (h_pos == '0));

    // R4
    hsync_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> blank);

    // R5
    mid_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && h_pos == HALF_M1) |=> mid_line);

    // R6
    field_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_id) |-> (line_pos == '0));

    // R7
    vsync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> (h_pos == (field_id ? HALF_PX : '0)));

    // R7
    vsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_n) |-> (h_pos == (field_id ? HALF_PX : '0)));

    // R8
    top_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (line_pos < VIS_LN) |-> blank);

endmodule

bind ilace_timing ilace_timing_chk #(
    .H_ACTIVE(H_ACTIVE),
    .H_FPORCH(H_FPORCH),
    .H_SYNC  (H_SYNC),
    .H_BPORCH(H_BPORCH),
    .V_ACTIVE(V_ACTIVE),
    .V_FPORCH(V_FPORCH),
    .V_SYNC  (V_SYNC),
    .V_BPORCH(V_BPORCH)
) u_ilace_chk (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .h_pos   (h_pos),
    .line_pos(line_pos),
    .field_id(field_id),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .blank   (blank),
    .mid_line(mid_line)
);

// File: tb/ilace_timing_bench.sv
module ilace_timing_bench;

    localparam int HA = 16, HF = 2, HS = 4, HB = 2;
    localparam int VA = 6, VF = 2, VS = 2, VBP = 3;
    localparam int HT = HA + HF + HS + HB;
    localparam int HALF = HT / 2;
    localparam int VL = VF + VS + VBP + VA;
    localparam int VB0 = VF + VS + VBP;
    localparam int HW = $clog2(HT);
    localparam int LW = $clog2(VL + 1);
    localparam int FRAME_CYC = HT * (2 * VL + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_en = 1'b0;
    logic [HW-1:0] h_pos;
    logic [LW-1:0] line_pos;
    logic          field_id;
    logic          hsync_n;
    logic          vsync_n;
    logic          blank;
    logic          mid_line;

    int checks = 0;
    int fails = 0;
    int eh = 0, el = 0, ef = 0;

    always #2 clk = ~clk;

    ilace_timing #(
        .H_ACTIVE(HA), .H_FPORCH(HF), .H_SYNC(HS), .H_BPORCH(HB),
        .V_ACTIVE(VA), .V_FPORCH(VF), .V_SYNC(VS), .V_BPORCH(VBP)
    ) u_ilace_timing (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .h_pos(h_pos), .line_pos(line_pos), .field_id(field_id),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .mid_line(mid_line)
    );

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (model line %0d h %0d field %0d)",
                     tag, act, exp, el, eh, ef);
        end
    endtask

    // reference position update, taken from R3 and R6
    task automatic model_step();
        if (ef == 0 && el == VL && eh == HALF - 1) begin
            ef = 1; el = 0; eh = HALF;
        end else if (ef == 1 && el == VL && eh == HT - 1) begin
            ef = 0; el = 0; eh = 0;
        end else if (eh == HT - 1) begin
            eh = 0; el++;
        end else begin
            eh++;
        end
    endtask

    function automatic int exp_vsync();
        bit low;
        if (ef == 0) low = (el >= VF) && (el < VF + VS);
        else low = ((el > VF) || (el == VF && eh >= HALF)) &&
                   ((el < VF + VS) || (el == VF + VS && eh < HALF));
        return low ? 0 : 1;
    endfunction

    task automatic check_all();
        int hs_e, bl_e, vs_e, mid_e;
        hs_e  = (eh >= HA + HF && eh < HA + HF + HS) ? 0 : 1;
        bl_e  = (eh < HA && el >= VB0 && el < VB0 + VA) ? 0 : 1;
        vs_e  = exp_vsync();
        mid_e = (eh == HALF) ? 1 : 0;
        check("R3 h_pos", int'(h_pos) == eh, int'(h_pos), eh);
        check("R6 line_pos", int'(line_pos) == el, int'(line_pos), el);
        check("R6 field_id", int'(field_id) == ef, int'(field_id), ef);
        check("R4 hsync_n", int'(hsync_n) == hs_e, int'(hsync_n), hs_e);
        check("R7 vsync_n", int'(vsync_n) == vs_e, int'(vsync_n), vs_e);
        check("R8 blank", int'(blank) == bl_e, int'(blank), bl_e);
        check("R5 mid_line", int'(mid_line) == mid_e, int'(mid_line), mid_e);
    endtask

    task automatic step(input bit en);
        pix_en = en;
        @(posedge clk);
        #1;
        if (en) model_step();
        check_all();
    endtask

    // R1: reset values
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        eh = 0; el = 0; ef = 0;
        check("R1 h_pos", h_pos == '0, int'(h_pos), 0);
        check("R1 line_pos", line_pos == '0, int'(line_pos), 0);
        check("R1 field_id", field_id == 1'b0, int'(field_id), 0);
        check("R1 hsync_n", hsync_n == 1'b1, int'(hsync_n), 1);
        check("R1 vsync_n", vsync_n == 1'b1, int'(vsync_n), 1);
        check("R1 blank", blank == 1'b1, int'(blank), 1);
        check("R1 mid_line", mid_line == 1'b0, int'(mid_line), 0);
        rst = 1'b0;
    endtask

    // R3 R4 R5 R6 R7 R8: two full frames with continuous enable, edge bookkeeping
    task automatic t_two_frames();
        int toggles = 0, f0_fall = 0, f1_fall = 0, lines_f0 = 0;
        bit pv = 1'b1, pf = 1'b0;
        for (int i = 0; i < 2 * FRAME_CYC; i++) begin
            step(1'b1);
            if (field_id != pf) toggles++;
            if (pv && !vsync_n) begin
                if (field_id) begin
                    f1_fall++;
                    check("R7 f1 fall h", int'(h_pos) == HALF, int'(h_pos), HALF);
                end else begin
                    f0_fall++;
                    check("R7 f0 fall h", h_pos == '0, int'(h_pos), 0);
                end
                check("R7 fall line", int'(line_pos) == VF, int'(line_pos), VF);
            end
            if (!field_id && h_pos == '0) lines_f0++;
            pv = vsync_n;
            pf = field_id;
        end
        check("R6 field toggles", toggles == 4, toggles, 4);
        check("R7 f0 vsync count", f0_fall == 2, f0_fall, 2);
        check("R7 f1 vsync count", f1_fall == 2, f1_fall, 2);
        check("R6 f0 line starts", lines_f0 == 2 * (VL + 1), lines_f0, 2 * (VL + 1));
    endtask

    // R2: enable gaps of varying length, including across the field seam
    task automatic t_stalls();
        for (int i = 0; i < FRAME_CYC + 200; i++) begin
            step(((i % 3) != 2) && ((i % 17) != 5));
        end
        for (int i = 0; i < 40; i++) step(1'b0);
        for (int i = 0; i < FRAME_CYC / 2; i++) step(1'b1);
    endtask

    // R1: reset taken in the middle of field 1
    task automatic t_mid_reset();
        while (ef == 0) step(1'b1);
        for (int i = 0; i < 3 * HT + 5; i++) step(1'b1);
        pix_en = 1'b1;
        t_reset();
        for (int i = 0; i < HT * 4; i++) step(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_two_frames();
        t_stalls();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule